// File: doc/BRIEF.md
# Chunk Run Allocator

This block keeps a record of which fixed-size chunks of a memory region are taken. It holds one occupancy bit per chunk and serves two kinds of request from a host. An allocate request carries a length in chunks and a placement policy. The block walks the occupancy bits looking for a contiguous run of free chunks that suits the policy. It marks the chosen run as taken and returns the index of its first chunk, or it reports that no suitable run exists. A free request carries a start index and a length. It releases those chunks only if every one of them is currently taken.

The host drives a request for one cycle while `busy` is low. A free request is answered on the next cycle. An allocate request starts a scan that examines one chunk per clock cycle, and `busy` stays high until the response appears. The running total of free chunks is always visible on `free_count`. Four placement policies are supported:

- first fit;
- next fit, which resumes from where the last allocation ended;
- best fit, which picks the smallest adequate run;
- worst fit, which picks the largest run.

Top module: `run_allocator`

## Requirements
- R1: After reset every chunk is free, `free_count` equals NCHUNK, `busy` is low and `rsp_valid` is low.
- R2: With `req_op`=0 (allocate) and `req_policy`=2'b00 (first fit), the block returns in `rsp_start` the lowest index at which `req_len` consecutive free chunks begin. It sets `rsp_ok`, marks those chunks taken and lowers `free_count` by `req_len`.
- R3: With `req_policy`=2'b01 (next fit), the scan begins at a remembered position. That position is 0 after reset, and each successful allocation of any policy moves it to (start+length) mod NCHUNK. The scan proceeds upward, wraps once to chunk 0 and stops just before its starting chunk. A run never spans chunk NCHUNK-1 to chunk 0, and the first run long enough is taken.
- R4: With `req_policy`=2'b10 (best fit), the block allocates at the start of the smallest free run whose length is at least `req_len`. When several runs tie, the lowest index wins.
- R5: With `req_policy`=2'b11 (worst fit), the block allocates at the start of the largest free run if that run is long enough. When several runs tie, the lowest index wins.
- R6: When no single free run is long enough, the allocation fails with `rsp_ok`=0 and `rsp_err`=0, even if `free_count` is at least `req_len`. The occupancy bits and `free_count` are left unchanged.
- R7: An allocation with `req_len` of 0 or above NCHUNK is answered on the cycle after acceptance with `rsp_ok`=0, and it changes nothing.
- R8: With `req_op`=1 (free), a range of `req_len` chunks from `req_start` in which every chunk is taken is released. The response comes on the next cycle with `rsp_ok`=1, and `free_count` rises by `req_len`.
- R9: A free request with zero length, a range past chunk NCHUNK-1, or any chunk already free in the range is answered with `rsp_err`=1 and `rsp_ok`=0. It leaves every bit and `free_count` unchanged.
- R10: A request is accepted only when `req_valid` is high and `busy` is low, and a request presented while `busy` is high is ignored. `busy` is never high in a cycle where `rsp_valid` is high. `rsp_valid` is a one-cycle pulse for each accepted request.
- R11: A scan examines one chunk per cycle. A successful first-fit or next-fit scan ends on the cycle that examines the last chunk of the chosen run. Best-fit, worst-fit and failing scans take exactly NCHUNK cycles of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 1 | 0 allocate, 1 free |
| req_policy | input | 2 | Placement policy for allocate |
| req_start | input | IDX_W | First chunk of a free request |
| req_len | input | LEN_W | Length in chunks |
| busy | output | 1 | Allocation scan in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Request succeeded |
| rsp_err | output | 1 | Free request rejected |
| rsp_start | output | IDX_W | First chunk of a successful allocation |
| free_count | output | LEN_W | Number of free chunks |

## Verification
The close of a free run and the last step of the scan can happen in the same cycle when the best candidate touches chunk NCHUNK-1. The final choice must then merge the run just completed with the stored candidate in a single decision. The bench provokes this by filling all chunks, opening holes, and then occupying every adequate hole below a two-chunk tail so that best fit must choose the tail. The result is judged by the returned start index and by the scan length. A second coincidence, a request arriving while a scan is running, is judged through `free_count`, the returned index and the absence of a second response pulse.

// File: rtl/alloc_pkg.sv
package alloc_pkg;

    typedef enum logic [1:0] {
        FIT_FIRST = 2'b00,
        FIT_NEXT  = 2'b01,
        FIT_BEST  = 2'b10,
        FIT_WORST = 2'b11
    } fit_e;

    typedef enum logic {
        OP_ALLOC = 1'b0,
        OP_FREE  = 1'b1
    } op_e;

    // Policies that stop at the first run long enough.
    function automatic logic fit_is_linear(fit_e p);
        return (p == FIT_FIRST) || (p == FIT_NEXT);
    endfunction

    // Whether a finished run of length cand replaces the stored candidate.
    function automatic logic fit_prefers(fit_e p, logic have, int unsigned cand, int unsigned held);
        if (!have)
            return 1'b1;
        if (p == FIT_BEST)
            return cand < held;
        return cand > held;
    endfunction

endpackage

// File: rtl/alloc_bitmap.sv
module alloc_bitmap #(
    parameter int NCHUNK = 32,
    parameter int IDX_W  = 5,
    parameter int LEN_W  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lo,
    input  logic [LEN_W-1:0] cnt,
    input  logic             set_en,
    input  logic             clr_en,
    output logic [NCHUNK-1:0] used_map,
    output logic [LEN_W-1:0] free_cnt,
    output logic             rng_ok,
    output logic             rng_all_used
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0]  hi_excl;
    logic [NCHUNK-1:0] sel;

    assign hi_excl = SUM_W'(lo) + SUM_W'(cnt);

    for (genvar i = 0; i < NCHUNK; i++) begin : g_sel
        assign sel[i] = (SUM_W'(i) >= SUM_W'(lo)) && (SUM_W'(i) < hi_excl);
    end

    assign rng_ok       = (cnt != '0) && (hi_excl <= SUM_W'(NCHUNK));
    assign rng_all_used = &(used_map | ~sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            used_map <= '0;
            free_cnt <= LEN_W'(NCHUNK);
        end else if (set_en) begin
            used_map <= used_map | sel;
            free_cnt <= free_cnt - cnt;
        end else if (clr_en) begin
            used_map <= used_map & ~sel;
            free_cnt <= free_cnt + cnt;
        end
    end

endmodule

// File: rtl/alloc_scan.sv
module alloc_scan
    import alloc_pkg::*;
#(
    parameter int NCHUNK = 32,
    parameter int IDX_W  = 5,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  fit_e              go_pol,
    input  logic [IDX_W-1:0]  go_origin,
    input  logic [LEN_W-1:0]  go_len,
    input  logic [NCHUNK-1:0] used_map,
    output logic              active,
    output logic              done,
    output logic              found,
    output logic [IDX_W-1:0]  pick_start,
    output logic [LEN_W-1:0]  pick_len
);
    localparam int PW = IDX_W + 1;

    fit_e             pol;
    logic [IDX_W-1:0] step, org, run_st, best_st;
    logic [LEN_W-1:0] run_len, best_len;
    logic             have;

    logic [PW-1:0]    raw_pos;
    logic [IDX_W-1:0] pos, nxt_idx, cur_st;
    logic [LEN_W-1:0] cur_len;
    logic             fr, restart, last, run_end, hit, cand, linear, fin;

    assign raw_pos = PW'(org) + PW'(step);
    assign pos     = (raw_pos >= PW'(NCHUNK)) ? IDX_W'(raw_pos - PW'(NCHUNK)) : IDX_W'(raw_pos);
    assign nxt_idx = (pos == IDX_W'(NCHUNK - 1)) ? '0 : pos + IDX_W'(1);
    assign fr      = !used_map[pos];
    assign last    = (step == IDX_W'(NCHUNK - 1));
    assign restart = (step == '0) || (pos == '0) || (run_len == '0);
    assign cur_len = !fr ? '0 : (restart ? LEN_W'(1) : run_len + LEN_W'(1));
    assign cur_st  = restart ? pos : run_st;
    assign run_end = fr && ((pos == IDX_W'(NCHUNK - 1)) || used_map[nxt_idx] || last);
    assign linear  = fit_is_linear(pol);
    assign hit     = linear && fr && (cur_len == pol_need());
    assign cand    = !linear && run_end && (cur_len >= pick_len)
                     && fit_prefers(pol, have, int'(cur_len), int'(best_len));
    assign fin     = hit || last;

    function automatic logic [LEN_W-1:0] pol_need();
        return pick_len;
    endfunction

    assign done       = active && fin;
    assign found      = linear ? hit : (have || cand);
    assign pick_start = (linear || cand) ? cur_st : best_st;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            pol      <= FIT_FIRST;
            step     <= '0;
            org      <= '0;
            pick_len <= '0;
            run_len  <= '0;
            run_st   <= '0;
            have     <= 1'b0;
            best_st  <= '0;
            best_len <= '0;
        end else if (go) begin
            active   <= 1'b1;
            pol      <= go_pol;
            step     <= '0;
            org      <= go_origin;
            pick_len <= go_len;
            run_len  <= '0;
            run_st   <= '0;
            have     <= 1'b0;
        end else if (active) begin
            if (fin) begin
                active <= 1'b0;
            end else begin
                step    <= step + IDX_W'(1);
                run_len <= cur_len;
                run_st  <= cur_st;
                if (cand) begin
                    have     <= 1'b1;
                    best_st  <= cur_st;
                    best_len <= cur_len;
                end
            end
        end
    end

endmodule

// File: rtl/run_allocator.sv
module run_allocator
    import alloc_pkg::*;
#(
    parameter  int NCHUNK = 32,
    localparam int IDX_W  = $clog2(NCHUNK),
    localparam int LEN_W  = $clog2(NCHUNK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_op,
    input  logic [1:0]       req_policy,
    input  logic [IDX_W-1:0] req_start,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic             rsp_err,
    output logic [IDX_W-1:0] rsp_start,
    output logic [LEN_W-1:0] free_count
);
    localparam int SUM_W = LEN_W + 1;

    fit_e              pol_in;
    logic              accept, free_try, alloc_try, len_bad, go, clr_ok, set_en;
    logic [IDX_W-1:0]  nf_ptr, origin, rng_lo;
    logic [LEN_W-1:0]  rng_cnt;
    logic [NCHUNK-1:0] used_map;
    logic              rng_ok, rng_all_used;
    logic              scan_done, scan_found;
    logic [IDX_W-1:0]  scan_start;
    logic [LEN_W-1:0]  scan_len;
    logic [SUM_W-1:0]  end_sum;

    assign pol_in    = fit_e'(req_policy);
    assign accept    = req_valid && !busy;
    assign free_try  = accept && (op_e'(req_op) == OP_FREE);
    assign alloc_try = accept && (op_e'(req_op) == OP_ALLOC);
    assign len_bad   = (req_len == '0) || (req_len > LEN_W'(NCHUNK));
    assign go        = alloc_try && !len_bad;
    assign origin    = (pol_in == FIT_NEXT) ? nf_ptr : '0;

    // The range port serves the scan result while busy, else the free request.
    assign rng_lo  = busy ? scan_start : req_start;
    assign rng_cnt = busy ? scan_len   : req_len;

    assign clr_ok  = free_try && rng_ok && rng_all_used;
    assign set_en  = scan_done && scan_found;
    assign end_sum = SUM_W'(scan_start) + SUM_W'(scan_len);

    alloc_bitmap #(.NCHUNK(NCHUNK), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_map (
        .clk          (clk),
        .rst          (rst),
        .lo           (rng_lo),
        .cnt          (rng_cnt),
        .set_en       (set_en),
        .clr_en       (clr_ok),
        .used_map     (used_map),
        .free_cnt     (free_count),
        .rng_ok       (rng_ok),
        .rng_all_used (rng_all_used)
    );

    alloc_scan #(.NCHUNK(NCHUNK), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_scan (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .go_pol     (pol_in),
        .go_origin  (origin),
        .go_len     (req_len),
        .used_map   (used_map),
        .active     (busy),
        .done       (scan_done),
        .found      (scan_found),
        .pick_start (scan_start),
        .pick_len   (scan_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_start <= '0;
            nf_ptr    <= '0;
        end else begin
            rsp_valid <= free_try || (alloc_try && len_bad) || scan_done;
            rsp_ok    <= clr_ok || set_en;
            rsp_err   <= free_try && !clr_ok;
            rsp_start <= set_en ? scan_start : '0;
            if (set_en)
                nf_ptr <= (end_sum >= SUM_W'(NCHUNK)) ? IDX_W'(end_sum - SUM_W'(NCHUNK))
                                                      : IDX_W'(end_sum);
        end
    end

endmodule

// File: rtl/run_allocator_chk.sv
module run_allocator_chk #(
    parameter  int NCHUNK = 32,
    localparam int LEN_W  = $clog2(NCHUNK + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic              rsp_err,
    input logic [LEN_W-1:0]  free_count,
    input logic [NCHUNK-1:0] used_map
);
    logic [LEN_W:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)
            busy_run <= '0;
        else if (busy)
            busy_run <= busy_run + 1'b1;
        else
            busy_run <= '0;
    end

    // R1
    count_matches_map_chk: assert property (@(posedge clk) disable iff (rst)
        int'(free_count) == NCHUNK - $countones(used_map));

    // R10
    busy_rsp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && rsp_valid));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R9
    err_excl_ok_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_ok && rsp_err));

    // R9
    err_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> $stable(used_map));

    // R6
    fail_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok && !rsp_err) |-> $stable(free_count));

    // R11
    scan_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(busy_run) <= NCHUNK);

endmodule

bind run_allocator run_allocator_chk #(.NCHUNK(NCHUNK)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .rsp_err    (rsp_err),
    .free_count (free_count),
    .used_map   (used_map)
);

// File: tb/run_allocator_test.sv
module run_allocator_test;
    localparam int N       = 32;
    localparam int IW      = $clog2(N);
    localparam int LW      = $clog2(N + 1);
    localparam int CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_op = 1'b0;
    logic [1:0]    req_policy = 2'b00;
    logic [IW-1:0] req_start = '0;
    logic [LW-1:0] req_len = '0;
    logic          busy, rsp_valid, rsp_ok, rsp_err;
    logic [IW-1:0] rsp_start;
    logic [LW-1:0] free_count;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER / 2) clk = ~clk;

    run_allocator #(.NCHUNK(N)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_policy(req_policy), .req_start(req_start), .req_len(req_len),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
        .rsp_start(rsp_start), .free_count(free_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Issue one request, wait for its response, sampling at falling edges.
    task automatic do_req(input logic op, input logic [1:0] pol, input int st, input int len,
                          output int ok, output int err, output int start, output int bcyc);
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_policy = pol;
        req_start  = IW'(st);
        req_len    = LW'(len);
        @(negedge clk);
        req_valid = 1'b0;
        bcyc = 0;
        for (int k = 0; k < 200 && !rsp_valid; k++) begin
            if (busy) bcyc++;
            @(negedge clk);
        end
        ok    = rsp_ok;
        err   = rsp_err;
        start = rsp_start;
        if (!rsp_valid) chk("R10 response missing", 0, 1);
    endtask

    task automatic alloc_expect(input string tag, input logic [1:0] pol, input int len,
                                input int exp_ok, input int exp_start);
        int ok, err, st, bc;
        do_req(1'b0, pol, 0, len, ok, err, st, bc);
        chk({tag, " ok"}, ok, exp_ok);
        if (exp_ok == 1) chk({tag, " start"}, st, exp_start);
    endtask

    task automatic free_expect(input string tag, input int st, input int len, input int exp_ok);
        int ok, err, s, bc;
        do_req(1'b1, 2'b00, st, len, ok, err, s, bc);
        chk({tag, " ok"}, ok, exp_ok);
        chk({tag, " err"}, err, 1 - exp_ok);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 free_count", free_count, N);
        chk("R1 busy", busy, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
    endtask

    task automatic t_first();
        int ok, err, st, bc;
        do_reset();
        do_req(1'b0, 2'b00, 0, 4, ok, err, st, bc);
        chk("R2 first ok", ok, 1);
        chk("R2 first start", st, 0);
        chk("R11 first scan cycles", bc, 4);
        alloc_expect("R2 second", 2'b00, 3, 1, 4);
        chk("R2 count", free_count, 25);
        free_expect("R8 free head", 0, 4, 1);
        chk("R8 count", free_count, 29);
        alloc_expect("R2 refill lowest", 2'b00, 2, 1, 0);
    endtask

    task automatic t_limits();
        int ok, err, st, bc;
        do_reset();
        do_req(1'b0, 2'b10, 0, 0, ok, err, st, bc);
        chk("R7 zero ok", ok, 0);
        chk("R7 zero latency", bc, 0);
        do_req(1'b0, 2'b00, 0, N + 1, ok, err, st, bc);
        chk("R7 oversize ok", ok, 0);
        chk("R7 count", free_count, N);
        free_expect("R9 free of free", 0, 2, 0);
        alloc_expect("R9 setup", 2'b00, 4, 1, 0);
        free_expect("R9 partly free", 2, 4, 0);
        free_expect("R9 past end", 30, 4, 0);
        free_expect("R9 zero length", 0, 0, 0);
        chk("R9 count unchanged", free_count, N - 4);
        free_expect("R8 valid free", 0, 4, 1);
        chk("R8 count", free_count, N);
    endtask

    task automatic t_pattern();
        int ok, err, st, bc;
        do_reset();
        do_req(1'b0, 2'b00, 0, N, ok, err, st, bc);
        chk("R11 full scan", bc, 32);
        free_expect("R8 hole a", 2, 3, 1);
        free_expect("R8 hole b", 10, 2, 1);
        free_expect("R8 hole c", 20, 8, 1);
        free_expect("R8 hole d", 30, 2, 1);
        chk("R8 count", free_count, 15);
        do_req(1'b0, 2'b10, 0, 2, ok, err, st, bc);
        chk("R4 best tie ok", ok, 1);
        chk("R4 best tie start", st, 10);
        chk("R11 best cycles", bc, 32);
        do_req(1'b0, 2'b10, 0, 2, ok, err, st, bc);
        chk("R4 best tail start", st, 30);
        free_expect("R8 restore", 10, 2, 1);
        free_expect("R8 restore", 30, 2, 1);
        alloc_expect("R4 best len3", 2'b10, 3, 1, 2);
        free_expect("R8 restore", 2, 3, 1);
        alloc_expect("R5 worst", 2'b11, 2, 1, 20);
        free_expect("R8 restore", 20, 2, 1);
        alloc_expect("R2 first pattern", 2'b00, 2, 1, 2);
        free_expect("R8 restore", 2, 2, 1);
        do_req(1'b0, 2'b10, 0, 9, ok, err, st, bc);
        chk("R6 fragmented ok", ok, 0);
        chk("R6 fragmented err", err, 0);
        chk("R6 count", free_count, 15);
        alloc_expect("R5 worst fills", 2'b11, 8, 1, 20);
        alloc_expect("R5 worst tie", 2'b11, 2, 1, 2);
    endtask

    task automatic t_next();
        do_reset();
        alloc_expect("R3 setup", 2'b00, 4, 1, 0);
        alloc_expect("R3 setup", 2'b00, 4, 1, 4);
        free_expect("R3 setup", 0, 4, 1);
        alloc_expect("R3 resumes", 2'b01, 2, 1, 8);
        do_reset();
        alloc_expect("R3 setup", 2'b00, 30, 1, 0);
        free_expect("R3 setup", 0, 4, 1);
        alloc_expect("R3 wrap no span", 2'b01, 3, 1, 0);
        alloc_expect("R3 from ptr", 2'b01, 2, 1, 30);
        alloc_expect("R3 stops", 2'b01, 2, 0, 0);
        chk("R6 count", free_count, 1);
    endtask

    task automatic t_ignore();
        int bc;
        do_reset();
        alloc_expect("R10 setup", 2'b00, 4, 1, 0);
        @(negedge clk);
        req_valid = 1'b1; req_op = 1'b0; req_policy = 2'b00; req_len = LW'(4);
        @(negedge clk);
        req_op = 1'b1; req_start = '0; req_len = LW'(4);
        chk("R10 busy", busy, 1);
        @(negedge clk);
        req_valid = 1'b0;
        bc = 0;
        for (int k = 0; k < 200 && !rsp_valid; k++) begin
            bc++;
            @(negedge clk);
        end
        chk("R10 alloc ok", rsp_ok, 1);
        chk("R10 alloc start", rsp_start, 4);
        chk("R11 scan cycles", bc + 1, 8);
        chk("R10 count", free_count, 24);
        @(negedge clk);
        chk("R10 single pulse", rsp_valid, 0);
        chk("R10 count after", free_count, 24);
    endtask

    initial begin
        t_reset();
        t_first();
        t_limits();
        t_pattern();
        t_next();
        t_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule